// File: doc/BRIEF.md
# Multiboot Fallback Boot Controller

This block picks the serial-flash start address for each configuration load attempt. A power-up or program-pin event starts a load from address zero and clears everything the block has stored. A bootstrap image can then program an update-image address and a golden-image address, each with a flash read opcode. It then issues an internal reprogram request, and the next load starts from the update image.

Each load attempt is a handshake. The block raises `start_o` for one cycle with the address and opcode valid, and keeps `busy_o` high until one result pulse arrives. The result is success, CRC error or watchdog timeout. A failed attempt counts a strike and the same image is tried again. On the third strike the block falls back to the golden image, which gets three strikes of its own. If the golden image also uses up its strikes, the block halts and raises `fail_o` until the next power-up event. Reading flash and parsing bitstreams are not part of this block.

Top module: `mbc_boot_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after a `por_i` pulse, `start_o`=1, `load_addr_o`=0, `load_opcode_o`=0x03, `strikes_o`=0, `status_o`=0 and `fail_o`=0. One cycle later `busy_o`=1.
- R2: A write with `reg_we_i`=1 stores `reg_wdata_i` in the register chosen by `reg_sel_i`: 0 = update low, 1 = update high, 2 = golden low, 3 = golden high. An image address is {high[7:0], low[15:0]} and its opcode is high[15:8].
- R3: `iprog_i` while the block is running (not busy, not starting, not halted) starts a new attempt on the next cycle. That attempt uses the update address and opcode, with strikes and status cleared.
- R4: `iprog_i` has no effect while an attempt is in progress or while halted.
- R5: A CRC error or watchdog timeout while busy adds one strike and sets the sticky status bit for that error (bit 3 for CRC, bit 2 for timeout). The next cycle starts a new attempt on the same image. If both arrive together they count as one strike.
- R6: The third strike on a non-golden image switches to the golden address and opcode, sets fallback status bit 1, clears the strikes and starts an attempt.
- R7: A success pulse while busy, with no error pulse in the same cycle, sets valid status bit 0, clears the strikes and ends the attempt.
- R8: The third strike on the golden image halts the block. It holds `fail_o`=1 and `strikes_o`=3 and starts no attempt until `por_i`.
- R9: Result pulses that arrive while no attempt is in progress change no output.
- R10: `por_i` clears the programmed addresses, so a later `iprog_i` loads from address 0.
- R11: `start_o` is high for exactly one cycle per attempt and is followed by `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-up / program-pin event, synchronous pulse |
| iprog_i | input | 1 | Internal reprogram request |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| load_ok_i | input | 1 | Attempt succeeded |
| crc_err_i | input | 1 | Attempt failed with CRC error |
| wdt_err_i | input | 1 | Attempt failed with watchdog timeout |
| start_o | output | 1 | Start pulse of a load attempt |
| busy_o | output | 1 | Attempt in progress |
| load_addr_o | output | 24 | Flash start address of the attempt |
| load_opcode_o | output | 8 | Flash read opcode of the attempt |
| strikes_o | output | 2 | Strikes used on the current image |
| status_o | output | 4 | {crc, timeout, fallback, valid} |
| fail_o | output | 1 | Golden image exhausted, halted |

## Verification
The directed part covers four patterns. A clean boot followed by an internal reprogram separates the zero address from the update address. Mixed CRC and timeout failures that stop short of three strikes show that retries stay on the same image. Exactly three failures show the switch to golden, and three more show the halt. A power-up event after programming shows that addresses are forgotten, which an internal reprogram alone would not do. The random phase mixes register writes, results arriving at both legal and stray times, and power-up events. This shows that the strike count, the sticky bits and the chosen image follow the attempt history rather than the input timing.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [1:0] {SRC_ZERO, SRC_UPDATE, SRC_GOLDEN} img_src_e;
  typedef enum logic [1:0] {ST_BOOT, ST_LOAD, ST_RUN, ST_HALT} boot_st_e;
  typedef enum logic [1:0] {SEL_UPD_LO, SEL_UPD_HI, SEL_GOLD_LO, SEL_GOLD_HI} reg_sel_e;
  localparam int unsigned STAT_VALID    = 0;
  localparam int unsigned STAT_FALLBACK = 1;
  localparam int unsigned STAT_WTO      = 2;
  localparam int unsigned STAT_CRC      = 3;
  localparam int unsigned STAT_W        = 4;
endpackage

// File: rtl/mbc_addr_regs.sv
module mbc_addr_regs #(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic                            we_i,
  input  logic [SEL_W-1:0]                sel_i,
  input  logic [REG_W-1:0]                wdata_i,
  output logic [NUM_REGS-1:0][REG_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_o[g] <= '0;
      else if (clr_i)                              regs_o[g] <= '0;
      else if (we_i && sel_i == SEL_W'(g))         regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/mbc_addr_mux.sv
module mbc_addr_mux
  import mbc_pkg::*;
#(
  parameter int unsigned REG_W      = 16,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned OP_W       = 8,
  parameter logic [7:0]  DEFAULT_OP = 8'h03,
  localparam int unsigned HI_W      = ADDR_W - REG_W
) (
  input  img_src_e               src_i,
  input  logic [3:0][REG_W-1:0]  regs_i,
  output logic [ADDR_W-1:0]      addr_o,
  output logic [OP_W-1:0]        op_o
);
  logic [REG_W-1:0] lo, hi;

  always_comb begin
    lo = '0;
    hi = '0;
    case (src_i)
      SRC_UPDATE: begin lo = regs_i[SEL_UPD_LO];  hi = regs_i[SEL_UPD_HI];  end
      SRC_GOLDEN: begin lo = regs_i[SEL_GOLD_LO]; hi = regs_i[SEL_GOLD_HI]; end
      default: ;
    endcase
    addr_o = {hi[HI_W-1:0], lo};
    op_o   = (src_i == SRC_ZERO) ? OP_W'(DEFAULT_OP) : hi[REG_W-1 -: OP_W];
  end
endmodule

// File: rtl/mbc_strike_ctr.sv
module mbc_strike_ctr #(
  parameter int unsigned LIMIT = 3,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_o <= '0;
    else if (clr_i)                              cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_W'(LIMIT))    cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              iprog_i,
  input  logic              ok_i,
  input  logic              crc_i,
  input  logic              wto_i,
  input  logic              last_strike_i,
  output boot_st_e          state_o,
  output img_src_e          src_o,
  output logic [STAT_W-1:0] status_o,
  output logic              strike_inc_o,
  output logic              strike_clr_o
);
  logic err, good, exhaust, reprog;

  assign err     = (state_o == ST_LOAD) && (crc_i || wto_i);
  assign good    = (state_o == ST_LOAD) && ok_i && !err;
  assign exhaust = err && last_strike_i;
  assign reprog  = (state_o == ST_RUN) && iprog_i;

  assign strike_inc_o = err;
  assign strike_clr_o = por_i || good || reprog || (exhaust && src_o != SRC_GOLDEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o  <= ST_BOOT;
      src_o    <= SRC_ZERO;
      status_o <= '0;
    end else if (por_i) begin
      state_o  <= ST_BOOT;
      src_o    <= SRC_ZERO;
      status_o <= '0;
    end else begin
      case (state_o)
        ST_BOOT: state_o <= ST_LOAD;
        ST_LOAD: begin
          if (err) begin
            if (crc_i) status_o[STAT_CRC] <= 1'b1;
            if (wto_i) status_o[STAT_WTO] <= 1'b1;
            if (exhaust && src_o == SRC_GOLDEN) begin
              state_o <= ST_HALT;
            end else if (exhaust) begin
              src_o                   <= SRC_GOLDEN;
              status_o[STAT_FALLBACK] <= 1'b1;
              state_o                 <= ST_BOOT;
            end else begin
              state_o <= ST_BOOT;
            end
          end else if (good) begin
            status_o[STAT_VALID] <= 1'b1;
            state_o              <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (reprog) begin
            src_o    <= SRC_UPDATE;
            status_o <= '0;
            state_o  <= ST_BOOT;
          end
        end
        default: state_o <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/mbc_boot_ctrl.sv
module mbc_boot_ctrl
  import mbc_pkg::*;
#(
  parameter int unsigned REG_W        = 16,
  parameter int unsigned ADDR_W       = 24,
  parameter int unsigned OP_W         = 8,
  parameter int unsigned STRIKE_LIMIT = 3,
  parameter logic [7:0]  DEFAULT_OP   = 8'h03,
  localparam int unsigned STRIKE_W    = $clog2(STRIKE_LIMIT + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                por_i,
  input  logic                iprog_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_sel_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  input  logic                load_ok_i,
  input  logic                crc_err_i,
  input  logic                wdt_err_i,
  output logic                start_o,
  output logic                busy_o,
  output logic [ADDR_W-1:0]   load_addr_o,
  output logic [OP_W-1:0]     load_opcode_o,
  output logic [STRIKE_W-1:0] strikes_o,
  output logic [STAT_W-1:0]   status_o,
  output logic                fail_o
);
  logic [3:0][REG_W-1:0] regs;
  boot_st_e state;
  img_src_e src;
  logic strike_inc, strike_clr, last_strike;

  mbc_addr_regs #(.REG_W(REG_W), .NUM_REGS(4)) u_regs (
    .clk_i, .rst_ni, .clr_i(por_i), .we_i(reg_we_i), .sel_i(reg_sel_i),
    .wdata_i(reg_wdata_i), .regs_o(regs)
  );

  mbc_addr_mux #(.REG_W(REG_W), .ADDR_W(ADDR_W), .OP_W(OP_W), .DEFAULT_OP(DEFAULT_OP)) u_mux (
    .src_i(src), .regs_i(regs), .addr_o(load_addr_o), .op_o(load_opcode_o)
  );

  mbc_strike_ctr #(.LIMIT(STRIKE_LIMIT)) u_strikes (
    .clk_i, .rst_ni, .clr_i(strike_clr), .inc_i(strike_inc),
    .cnt_o(strikes_o), .last_o(last_strike)
  );

  mbc_seq u_seq (
    .clk_i, .rst_ni, .por_i, .iprog_i, .ok_i(load_ok_i), .crc_i(crc_err_i),
    .wto_i(wdt_err_i), .last_strike_i(last_strike), .state_o(state), .src_o(src),
    .status_o, .strike_inc_o(strike_inc), .strike_clr_o(strike_clr)
  );

  assign start_o = (state == ST_BOOT);
  assign busy_o  = (state == ST_LOAD);
  assign fail_o  = (state == ST_HALT);
endmodule

// File: rtl/mbc_boot_ctrl_chk.sv
module mbc_boot_ctrl_chk #(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned OP_W     = 8,
  parameter int unsigned STRIKE_W = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                por_i,
  input logic                iprog_i,
  input logic                reg_we_i,
  input logic [1:0]          reg_sel_i,
  input logic [REG_W-1:0]    reg_wdata_i,
  input logic                load_ok_i,
  input logic                crc_err_i,
  input logic                wdt_err_i,
  input logic                start_o,
  input logic                busy_o,
  input logic [ADDR_W-1:0]   load_addr_o,
  input logic [OP_W-1:0]     load_opcode_o,
  input logic [STRIKE_W-1:0] strikes_o,
  input logic [3:0]          status_o,
  input logic                fail_o
);
  AST_POR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (start_o && load_addr_o == '0 && strikes_o == '0 && status_o == '0 && !fail_o)); // R1

  AST_IPROG_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iprog_i && !por_i && !busy_o && !start_o && !fail_o) |=> (start_o && strikes_o == '0 && status_o == '0)); // R3

  AST_IPROG_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iprog_i && busy_o && !por_i && !load_ok_i && !crc_err_i && !wdt_err_i) |=> busy_o); // R4

  AST_ERR_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (crc_err_i || wdt_err_i) && !por_i) |=> (start_o || fail_o)); // R5

  AST_FALLBACK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> (start_o && strikes_o == '0)); // R6

  AST_SUCCESS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && load_ok_i && !crc_err_i && !wdt_err_i && !por_i) |=> (status_o[0] && strikes_o == '0 && !busy_o)); // R7

  AST_FAIL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !por_i) |=> fail_o); // R8

  AST_FAIL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!start_o && !busy_o)); // R8

  AST_STRAY_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !por_i && !iprog_i) |=> $stable(status_o)); // R9

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !por_i) |=> (!start_o && busy_o)); // R11
endmodule

bind mbc_boot_ctrl mbc_boot_ctrl_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .OP_W(OP_W), .STRIKE_W(STRIKE_W)
) u_chk (.*);

// File: tb/mbc_boot_ctrl_test.sv
module mbc_boot_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PH_BOOT = 0, PH_LOAD = 1, PH_RUN = 2, PH_HALT = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0, por_i = 1'b0, iprog_i = 1'b0;
  logic reg_we_i = 1'b0;
  logic [1:0] reg_sel_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic load_ok_i = 1'b0, crc_err_i = 1'b0, wdt_err_i = 1'b0;
  logic start_o, busy_o, fail_o;
  logic [23:0] load_addr_o;
  logic [7:0] load_opcode_o;
  logic [1:0] strikes_o;
  logic [3:0] status_o;

  int unsigned errors = 0, checks = 0;
  logic [15:0] m_regs [4];
  int m_src = 0, m_strikes = 0, m_phase = PH_BOOT;
  logic [3:0] m_status = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mbc_boot_ctrl uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_addr();
    case (m_src)
      1: return {m_regs[1][7:0], m_regs[0]};
      2: return {m_regs[3][7:0], m_regs[2]};
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] exp_op();
    case (m_src)
      1: return m_regs[1][15:8];
      2: return m_regs[3][15:8];
      default: return 8'h03;
    endcase
  endfunction

  task automatic check_all(input string req);
    check({req, " addr"}, 32'(load_addr_o), 32'(exp_addr()));
    check({req, " opcode"}, 32'(load_opcode_o), 32'(exp_op()));
    check({req, " strikes"}, 32'(strikes_o), 32'(m_strikes));
    check({req, " status"}, 32'(status_o), 32'(m_status));
    check({req, " start"}, 32'(start_o), 32'(m_phase == PH_BOOT));
    check({req, " busy"}, 32'(busy_o), 32'(m_phase == PH_LOAD));
    check({req, " fail"}, 32'(fail_o), 32'(m_phase == PH_HALT));
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // new attempt: one start cycle then busy (R11)
  task automatic enter_load();
    tick();
    m_phase = PH_LOAD;
    check_all("R11");
  endtask

  task automatic do_por();
    por_i = 1'b1;
    tick();
    por_i = 1'b0;
    for (int i = 0; i < 4; i++) m_regs[i] = '0;
    m_src = 0; m_strikes = 0; m_status = '0; m_phase = PH_BOOT;
    check_all("R1");
    enter_load();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = data;
    tick();
    reg_we_i = 1'b0;
    m_regs[sel] = data;
    check_all("R2");
  endtask

  task automatic result(input logic ok, input logic crc, input logic wto);
    load_ok_i = ok; crc_err_i = crc; wdt_err_i = wto;
    tick();
    load_ok_i = 1'b0; crc_err_i = 1'b0; wdt_err_i = 1'b0;
    if (m_phase != PH_LOAD) begin
      check_all("R9");
    end else if (crc || wto) begin
      m_strikes++;
      if (crc) m_status[3] = 1'b1;
      if (wto) m_status[2] = 1'b1;
      if (m_strikes == 3 && m_src != 2) begin
        m_src = 2; m_status[1] = 1'b1; m_strikes = 0; m_phase = PH_BOOT;
        check_all("R6");
      end else if (m_strikes == 3) begin
        m_phase = PH_HALT;
        check_all("R8");
      end else begin
        m_phase = PH_BOOT;
        check_all("R5");
      end
      if (m_phase == PH_BOOT) enter_load();
    end else if (ok) begin
      m_status[0] = 1'b1; m_strikes = 0; m_phase = PH_RUN;
      check_all("R7");
    end
  endtask

  task automatic iprog();
    iprog_i = 1'b1;
    tick();
    iprog_i = 1'b0;
    if (m_phase == PH_RUN) begin
      m_src = 1; m_strikes = 0; m_status = '0; m_phase = PH_BOOT;
      check_all("R3");
      enter_load();
    end else begin
      check_all("R4");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) m_regs[i] = '0;
    repeat (3) tick();
    check_all("R1");
    rst_ni = 1'b1;
    enter_load();

    // program update 0x200000 and golden 0x010000, both opcode 0x03
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0320);
    wr(2'd2, 16'h0000); wr(2'd3, 16'h0301);
    result(1'b1, 1'b0, 1'b0);
    result(1'b0, 1'b1, 1'b0);                  // stray, R9
    result(1'b1, 1'b0, 1'b1);                  // stray, R9
    iprog();                                   // R3: update image
    check("R3 update addr", 32'(load_addr_o), 32'h200000);
    iprog();                                   // R4: ignored while busy
    result(1'b0, 1'b1, 1'b0);                  // R5 strike 1
    result(1'b0, 1'b0, 1'b1);                  // R5 strike 2
    result(1'b0, 1'b1, 1'b0);                  // R6 fallback
    check("R6 golden addr", 32'(load_addr_o), 32'h010000);
    result(1'b0, 1'b1, 1'b1);                  // R5 both at once, one strike
    result(1'b0, 1'b0, 1'b1);
    result(1'b1, 1'b0, 1'b0);                  // R7 golden ok
    iprog();
    for (int i = 0; i < 6; i++) result(1'b0, 1'b0, 1'b1);  // R8 halt
    check("R8 fail", 32'(fail_o), 32'd1);
    iprog();                                   // R4 ignored in halt
    result(1'b1, 1'b0, 1'b0);                  // R9 ignored in halt
    repeat (3) tick();
    check_all("R8");
    do_por();                                  // R1
    result(1'b1, 1'b0, 1'b0);
    iprog();                                   // R10: addresses forgotten
    check("R10 addr", 32'(load_addr_o), 32'h0);

    for (int n = 0; n < 600; n++) begin
      int unsigned r = $urandom % 20;
      case (m_phase)
        PH_LOAD: begin
          if (r < 2) wr(2'($urandom), 16'($urandom));
          else if (r < 10) result(1'b1, 1'b0, 1'b0);
          else if (r < 14) result(1'b0, 1'b1, 1'b0);
          else if (r < 18) result(1'b0, 1'b0, 1'b1);
          else result(1'b0, 1'b1, 1'b1);
        end
        PH_RUN: begin
          if (r < 6) wr(2'($urandom), 16'($urandom));
          else if (r < 12) iprog();
          else if (r < 18) result(1'($urandom), 1'($urandom), 1'($urandom));
          else do_por();
        end
        default: begin
          if (r < 10) result(1'($urandom), 1'($urandom), 1'($urandom));
          else do_por();
        end
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule